// File: doc/BRIEF.md
# Transmit Byte-Bus Frame Aligner

This block sits on the transmit side of a byte-wide SONET/SDH add bus, in the same clock domain as the local frame reference. A frame counter produces a reference strobe of one clock, once per frame. The upstream device uses this strobe to place the first overhead byte (C1/J0) of each frame. A control input can move the strobe one clock earlier, which gives the upstream logic one more cycle to fetch that byte.

The block watches a single marker input that carries frame-start and payload-start pulses. A 2-bit slot select sets the expected position of the frame-start pulse as an offset of 0 to 3 bytes from the frame boundary. A frame-start pulse at any other position raises a one-cycle misalignment flag.

There are two modes, set by a retiming enable:
- **Retiming off:** the payload-envelope input is ignored. Every marker pulse counts as a frame start, and no payload-start pulse is expected.
- **Retiming on:** a marker pulse while the envelope input is high is a payload-start (J1) pulse. A marker pulse while it is low is a frame-start (C1) pulse. Each C1 pulse must be followed by a J1 pulse within one frame, or a missing-J1 flag is raised.

The incoming bytes are passed through one register stage, together with a flag that marks the frame-start byte.

**Alignment states:**
- `ST_FIRST`: the first frame after reset. No reference exists yet, and markers are ignored.
- `ST_RUN`: checking is active.
- Transition: `ST_FIRST` → `ST_RUN` when the counter wraps from its last value. `ST_RUN` holds until reset.

**Payload-start watch states:**
- `JW_IDLE`: no window is open. Leaves for `JW_WAIT` on a C1 pulse while armed with retiming on.
- `JW_WAIT`: a window of L−1 cycles is open after a C1 pulse.
  - Back to `JW_IDLE` when a J1 pulse arrives.
  - Back to `JW_IDLE` with the flag raised when the window expires.
  - Restarts the window when a new C1 pulse arrives.
  - Back to `JW_IDLE` whenever retiming is off.

Top module: `txfa_top`

## Requirements
In these requirements, L is FRAME_LEN. Cycle n counts clocks from the first clock sampled with reset low, starting at n = 0. The frame boundary of frame f (f ≥ 1) is cycle f·L.

- R1: While reset is high, and in cycle 0, frame_ref, misalign, j1_missing and out_sof are all 0.
- R2: With early_frame = 0, frame_ref is 1 in cycles L−1, 2L−1, 3L−1, … and is 0 in every other cycle. The pulse is never longer than one cycle.
- R3: With early_frame = 1, frame_ref is 1 in cycles L−2, 2L−2, … and is 0 at L−1.
- R4: A marker pulse in cycles 0 to L−1 (the first frame, state ST_FIRST) raises no flag.
- R5: A frame-start pulse in cycle f·L + slot_sel raises no misalignment. A frame-start pulse in any other armed cycle sets misalign to 1 in the next cycle only.
- R6: Each slot_sel value from 1 to 3 moves the expected frame-start cycle to f·L + slot_sel. A pulse one cycle before that position is flagged.
- R7: With retime_en = 0, bus_spe is ignored: a marker pulse with bus_spe = 1 is judged as a frame start. In this mode j1_missing stays 0.
- R8: With retime_en = 1, a marker pulse with bus_spe = 1 is a J1 pulse and never causes misalign. A marker pulse with bus_spe = 0 is a frame start and is checked as in R5.
- R9: With retime_en = 1, a frame-start pulse in cycle t that is followed by no J1 pulse in cycles t+1 to t+L−1 makes j1_missing 1 in cycle t+L only.
- R10: A J1 pulse anywhere in cycles t+1 to t+L−1, including the last cycle t+L−1, prevents j1_missing.
- R11: out_data equals the bus_data of the previous cycle. out_sof is 1 in cycle f·L + 1, marking the byte taken at the frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the bus and the reference |
| rst | input | 1 | Synchronous active-high reset |
| early_frame | input | 1 | 1 moves frame_ref one cycle earlier |
| retime_en | input | 1 | 1 selects the retiming marker rules |
| slot_sel | input | 2 | Expected frame-start offset from the frame boundary, in bytes |
| bus_data | input | 8 | Incoming transmit byte |
| bus_spe | input | 1 | Payload-envelope indicator; used only with retiming on |
| bus_marker | input | 1 | Combined frame-start / payload-start marker |
| frame_ref | output | 1 | One-cycle frame reference strobe |
| misalign | output | 1 | One-cycle flag for a frame-start pulse at the wrong position |
| j1_missing | output | 1 | One-cycle flag for a J1 pulse absent for a full frame |
| out_data | output | 8 | bus_data delayed one cycle |
| out_sof | output | 1 | Marks the out_data byte taken at the frame boundary |

## Verification
The hardest case to reach is the end of the J1 window. A J1 pulse on the last cycle of the window, t+L−1, must cancel the flag. One cycle of silence past that point must raise the flag in exactly cycle t+L. To reach this, the bench shortens the frame to 32 bytes and places a single C1 pulse on the first armed frame boundary. In one run it sends no J1 pulse at all, and in a second run it sends the J1 pulse exactly on the window's final cycle. A bench cycle index, zeroed at reset release, sets the timing of both runs. The first-frame blanking and slot offsets are reached the same way, with pulses placed one cycle on either side of the expected slot.

// File: rtl/txfa_pkg.sv
`timescale 1ns/1ps
package txfa_pkg;

    typedef enum logic {
        ST_FIRST,
        ST_RUN
    } align_state_e;

    typedef enum logic {
        JW_IDLE,
        JW_WAIT
    } j1_state_e;

    typedef struct packed {
        logic c1;
        logic j1;
    } marker_evt_t;

endpackage

// File: rtl/txfa_frame_timer.sv
`timescale 1ns/1ps
module txfa_frame_timer
    import txfa_pkg::*;
#(
    parameter int FRAME_LEN = 2430,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             early_frame,
    output logic [CNT_W-1:0] cnt,
    output logic             armed,
    output logic             frame_ref
);

    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] EARLY_POS = CNT_W'(FRAME_LEN - 2);

    align_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] ref_pos;
    logic             ref_d;

    // next state: leave the blind first frame at the first wrap
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FIRST: if (cnt == LAST_POS) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        cnt_d = (cnt == LAST_POS) ? '0 : cnt + CNT_W'(1);
    end

    // state register and byte counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FIRST;
            cnt     <= '0;
        end else begin
            state_q <= state_d;
            cnt     <= cnt_d;
        end
    end

    // output process: reference strobe is registered, never two cycles long
    always_comb begin
        ref_pos = early_frame ? EARLY_POS : LAST_POS;
        ref_d   = (cnt_d == ref_pos) && !frame_ref;
    end

    always_ff @(posedge clk) begin
        if (rst) frame_ref <= 1'b0;
        else     frame_ref <= ref_d;
    end

    assign armed = (state_q == ST_RUN);

    assert_ref_single_R2: assert property (@(posedge clk) disable iff (rst)
        frame_ref |=> !frame_ref);

    assert_armed_after_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> (cnt == '0));

endmodule

// File: rtl/txfa_marker_decode.sv
`timescale 1ns/1ps
module txfa_marker_decode
    import txfa_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retime_en,
    input  logic              marker,
    input  logic              spe,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              armed,
    input  logic [SLOT_W-1:0] slot_sel,
    output marker_evt_t       evt,
    output logic              misalign
);

    logic [CNT_W-1:0] expect_pos;
    logic             off_slot;

    // classify the marker: without retiming every pulse is a frame start
    always_comb begin
        evt.c1 = marker && (!retime_en || !spe);
        evt.j1 = marker && retime_en && spe;
    end

    always_comb begin
        expect_pos = CNT_W'(slot_sel);
        off_slot   = (cnt != expect_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) misalign <= 1'b0;
        else     misalign <= evt.c1 && armed && off_slot;
    end

    assert_misalign_cause_R5: assert property (@(posedge clk) disable iff (rst)
        misalign |-> $past(marker));

    assert_first_frame_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!armed) |-> !misalign);

    assert_j1_no_misalign_R8: assert property (@(posedge clk) disable iff (rst)
        (retime_en && marker && spe) |=> !misalign);

endmodule

// File: rtl/txfa_j1_watch.sv
`timescale 1ns/1ps
module txfa_j1_watch
    import txfa_pkg::*;
#(
    parameter int FRAME_LEN = 2430,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        retime_en,
    input  logic        armed,
    input  marker_evt_t evt,
    output logic        j1_missing
);

    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(FRAME_LEN - 1);

    j1_state_e        state_q, state_d;
    logic [CNT_W-1:0] wcnt_q, wcnt_d;
    logic             miss_d;

    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        miss_d  = 1'b0;
        if (!retime_en) begin
            state_d = JW_IDLE;
            wcnt_d  = '0;
        end else begin
            unique case (state_q)
                JW_IDLE: begin
                    if (evt.c1 && armed) begin
                        state_d = JW_WAIT;
                        wcnt_d  = CNT_W'(1);
                    end
                end
                JW_WAIT: begin
                    if (evt.j1) begin
                        state_d = JW_IDLE;
                        wcnt_d  = '0;
                    end else if (wcnt_q == WIN_END) begin
                        miss_d  = 1'b1;
                        state_d = evt.c1 ? JW_WAIT : JW_IDLE;
                        wcnt_d  = evt.c1 ? CNT_W'(1) : '0;
                    end else if (evt.c1) begin
                        wcnt_d  = CNT_W'(1);
                    end else begin
                        wcnt_d  = wcnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= JW_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) j1_missing <= 1'b0;
        else     j1_missing <= miss_d;
    end

    assert_j1_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!retime_en) |-> !j1_missing);

    assert_wait_bound_R9: assert property (@(posedge clk) disable iff (rst)
        wcnt_q <= WIN_END);

    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == JW_IDLE) |-> (wcnt_q == '0));

endmodule

// File: rtl/txfa_top.sv
`timescale 1ns/1ps
module txfa_top
    import txfa_pkg::*;
#(
    parameter int FRAME_LEN = 2430,
    parameter int DATA_W    = 8,
    parameter int SLOT_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              early_frame,
    input  logic              retime_en,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_spe,
    input  logic              bus_marker,
    output logic              frame_ref,
    output logic              misalign,
    output logic              j1_missing,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sof
);

    localparam int CNT_W = $clog2(FRAME_LEN);

    logic [CNT_W-1:0] cnt;
    logic             armed;
    marker_evt_t      evt;

    txfa_frame_timer #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .early_frame (early_frame),
        .cnt         (cnt),
        .armed       (armed),
        .frame_ref   (frame_ref)
    );

    txfa_marker_decode #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .retime_en (retime_en),
        .marker    (bus_marker),
        .spe       (bus_spe),
        .cnt       (cnt),
        .armed     (armed),
        .slot_sel  (slot_sel),
        .evt       (evt),
        .misalign  (misalign)
    );

    txfa_j1_watch #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_j1 (
        .clk        (clk),
        .rst        (rst),
        .retime_en  (retime_en),
        .armed      (armed),
        .evt        (evt),
        .j1_missing (j1_missing)
    );

    // byte pass-through with frame-boundary tag
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_sof  <= 1'b0;
        end else begin
            out_data <= bus_data;
            out_sof  <= armed && (cnt == '0);
        end
    end

    assert_sof_follows_ref_R11: assert property (@(posedge clk) disable iff (rst)
        (out_sof && !early_frame) |-> $past(frame_ref, 2));

    assert_data_delay_R11: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (out_data == $past(bus_data)));

endmodule

// File: tb/test_txfa_top.sv
`timescale 1ns/1ps
module test_txfa_top;

    localparam int L = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       early_frame = 1'b0;
    logic       retime_en = 1'b0;
    logic [1:0] slot_sel = 2'd0;
    logic [7:0] bus_data = 8'd0;
    logic       bus_spe = 1'b0;
    logic       bus_marker = 1'b0;
    logic       frame_ref, misalign, j1_missing, out_sof;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int n = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txfa_top #(.FRAME_LEN(L)) i_txfa_top (
        .clk(clk), .rst(rst), .early_frame(early_frame), .retime_en(retime_en),
        .slot_sel(slot_sel), .bus_data(bus_data), .bus_spe(bus_spe),
        .bus_marker(bus_marker), .frame_ref(frame_ref), .misalign(misalign),
        .j1_missing(j1_missing), .out_data(out_data), .out_sof(out_sof)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, n, act, exp);
        end
    endtask

    task automatic advance_to(input int m);
        while (n < m) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_reset(input bit early, input bit retime, input int slot);
        @(negedge clk);
        rst = 1'b1;
        early_frame = early;
        retime_en = retime;
        slot_sel = 2'(slot);
        bus_marker = 1'b0;
        bus_spe = 1'b0;
        bus_data = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n = 0;
    endtask

    task automatic pulse(input int m, input bit spe);
        advance_to(m);
        bus_marker = 1'b1;
        bus_spe = spe;
        advance_to(m + 1);
        bus_marker = 1'b0;
        bus_spe = 1'b0;
    endtask

    task automatic t_reset_and_period();
        int hits = 0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check({frame_ref, misalign, j1_missing, out_sof} == 4'b0, "R1 in reset",
              int'({frame_ref, misalign, j1_missing, out_sof}), 0);
        do_reset(1'b0, 1'b0, 0);
        check({frame_ref, misalign, j1_missing, out_sof} == 4'b0, "R1 cycle0",
              int'({frame_ref, misalign, j1_missing, out_sof}), 0);
        for (int k = 1; k < L - 1; k++) begin
            advance_to(k);
            if (frame_ref) hits++;
        end
        check(hits == 0, "R2 quiet first frame", hits, 0);
        advance_to(L - 1);
        check(frame_ref == 1'b1, "R2 first ref", int'(frame_ref), 1);
        advance_to(L);
        check(frame_ref == 1'b0, "R2 width", int'(frame_ref), 0);
        advance_to(2 * L - 1);
        check(frame_ref == 1'b1, "R2 period", int'(frame_ref), 1);
    endtask

    task automatic t_early();
        do_reset(1'b1, 1'b0, 0);
        advance_to(L - 2);
        check(frame_ref == 1'b1, "R3 early ref", int'(frame_ref), 1);
        advance_to(L - 1);
        check(frame_ref == 1'b0, "R3 nominal slot empty", int'(frame_ref), 0);
        advance_to(2 * L - 2);
        check(frame_ref == 1'b1, "R3 second early ref", int'(frame_ref), 1);
    endtask

    task automatic t_first_frame();
        do_reset(1'b0, 1'b0, 0);
        pulse(5, 1'b0);
        check(misalign == 1'b0, "R4 early marker", int'(misalign), 0);
        pulse(L - 1, 1'b0);
        check(misalign == 1'b0, "R4 last unarmed cycle", int'(misalign), 0);
    endtask

    task automatic t_aligned();
        do_reset(1'b0, 1'b0, 0);
        pulse(L, 1'b0);
        check(misalign == 1'b0, "R5 aligned", int'(misalign), 0);
        pulse(L + 3, 1'b0);
        check(misalign == 1'b1, "R5 misplaced", int'(misalign), 1);
        advance_to(L + 5);
        check(misalign == 1'b0, "R5 one cycle", int'(misalign), 0);
    endtask

    task automatic t_slots();
        for (int s = 1; s < 4; s++) begin
            do_reset(1'b0, 1'b0, s);
            pulse(L + s, 1'b0);
            check(misalign == 1'b0, "R6 slot match", int'(misalign), 0);
            pulse(2 * L + s - 1, 1'b0);
            check(misalign == 1'b1, "R6 one before slot", int'(misalign), 1);
        end
    endtask

    task automatic t_retime_off();
        int seen = 0;
        do_reset(1'b0, 1'b0, 0);
        pulse(L + 2, 1'b1);
        check(misalign == 1'b1, "R7 spe ignored", int'(misalign), 1);
        pulse(2 * L, 1'b1);
        check(misalign == 1'b0, "R7 aligned with spe", int'(misalign), 0);
        while (n < 4 * L) begin
            advance_to(n + 1);
            if (j1_missing) seen++;
        end
        check(seen == 0, "R7 no j1 flag", seen, 0);
    endtask

    task automatic t_retime_on();
        int seen = 0;
        do_reset(1'b0, 1'b1, 1);
        pulse(L + 1, 1'b0);
        check(misalign == 1'b0, "R8 c1 aligned", int'(misalign), 0);
        pulse(L + 10, 1'b1);
        check(misalign == 1'b0, "R8 j1 not c1", int'(misalign), 0);
        pulse(L + 20, 1'b0);
        check(misalign == 1'b1, "R8 spe low is c1", int'(misalign), 1);
        pulse(L + 25, 1'b1);
        while (n < 2 * L + 5) begin
            advance_to(n + 1);
            if (j1_missing) seen++;
        end
        check(seen == 0, "R10 j1 present", seen, 0);
    endtask

    task automatic t_j1_window();
        do_reset(1'b0, 1'b1, 0);
        pulse(L, 1'b0);
        advance_to(2 * L - 1);
        check(j1_missing == 1'b0, "R9 before window end", int'(j1_missing), 0);
        advance_to(2 * L);
        check(j1_missing == 1'b1, "R9 missing", int'(j1_missing), 1);
        advance_to(2 * L + 1);
        check(j1_missing == 1'b0, "R9 one cycle", int'(j1_missing), 0);
        do_reset(1'b0, 1'b1, 0);
        pulse(L, 1'b0);
        pulse(2 * L - 1, 1'b1);
        check(j1_missing == 1'b0, "R10 j1 on last cycle", int'(j1_missing), 0);
        advance_to(2 * L + 1);
        check(j1_missing == 1'b0, "R10 after window", int'(j1_missing), 0);
    endtask

    task automatic t_data();
        do_reset(1'b0, 1'b0, 0);
        for (int m = L - 2; m <= L + 3; m++) begin
            advance_to(m);
            if (m > L - 2)
                check(out_data == 8'(m - 1 + 7), "R11 data delay", int'(out_data), (m - 1 + 7) & 255);
            if (m == L + 1)
                check(out_sof == 1'b1, "R11 sof", int'(out_sof), 1);
            else
                check(out_sof == 1'b0, "R11 no sof", int'(out_sof), 0);
            bus_data = 8'(m + 7);
        end
    endtask

    initial begin
        t_reset_and_period();
        t_early();
        t_first_frame();
        t_aligned();
        t_slots();
        t_retime_off();
        t_retime_on();
        t_j1_window();
        t_data();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule